// File: doc/BRIEF.md
# Address-Latched PRG Bank Mapper

This block is a cartridge bank-switching controller that sits on the bus of an 8-bit console. It holds one configuration register. The register is loaded from the CPU address of a write, not from the data bus. Only writes into the $8000-$9FFF window reach it. The register selects a program ROM bank, a bank size of 16K or 32K, and a nametable mirroring arrangement. From the register and the live CPU address, the block drives the upper program ROM address lines A19..A14 and a mirroring output.

A lock flag in the same register is sticky. Once software sets it, the mapper ignores every later write, and only a reset clears it. Reset clears every register bit. The reset input is asynchronous and active high.

Top module: `prg_latch_mapper`

## Requirements
- R1: A register write takes place on a rising clock edge only when rom_sel_n is low, cpu_rw is low, and cpu_addr[15:13] equals 3'b100. Writes with any other value of cpu_addr[15:13] (for example $A000, $C000 or $E000) leave the register unchanged. The same holds for writes made while rom_sel_n is high.
- R2: The block has no data input. All register contents come from cpu_addr of the accepted write.
- R3: cpu_addr[0] of an accepted write sets the bank size: 0 selects 16K and 1 selects 32K.
- R4: cpu_addr[1] of an accepted write drives mirror_h from the next cycle: 0 selects vertical and 1 selects horizontal.
- R5: The six bank bits for PRG A19..A14 are taken from cpu_addr bits 8, 6, 5, 4, 3 and 2, in that order. cpu_addr[2] is the A14 bit and cpu_addr[8] is the A19 bit. prg_addr_hi[5:1] always equal the latched A19..A15 bits.
- R6: In 16K mode, prg_addr_hi[0] equals the latched A14 bit for every CPU address, including both $8000-$BFFF and $C000-$FFFF.
- R7: In 32K mode, the latched A14 bit is ignored and prg_addr_hi[0] follows cpu_addr[14].
- R8: While rst is high, all register bits are zero, so prg_addr_hi reads 0 (in 16K mode) and mirror_h reads 0. Reset acts without waiting for a clock edge.
- R9: An accepted write with cpu_addr[7]=1 sets the lock flag. After that, every write is ignored until the next reset, in either bank-size mode.
- R10: A cycle with cpu_rw high never changes the register, whatever the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| cpu_addr | input | 16 | CPU address bus |
| cpu_rw | input | 1 | CPU read/write, low for write |
| rom_sel_n | input | 1 | ROM select strobe, active low |
| prg_addr_hi | output | 6 | Program ROM address lines A19..A14 |
| mirror_h | output | 1 | Mirroring select, 1 for horizontal |

## Verification
The hardest state to reach is the locked one, because its effect is an absence of change. The stimulus first sets the lock together with a known bank. It then aims writes carrying a different bank, size and mirroring into the active window, and checks both CPU halves so that a size change would show up on prg_addr_hi[0]. After an asynchronous reset, the same kind of write has to take effect again. Every cycle is compared against a behavioural model, and that model also covers near misses: writes just above the window, with the strobe inactive, or with R/W high.

// File: rtl/prg_latch_mapper.sv
module prg_latch_mapper #(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rw,
  input  logic              rom_sel_n,
  output logic [BANK_W-1:0] prg_addr_hi,
  output logic              mirror_h
);

  logic [BANK_W-1:0] bank_q;
  logic              size32_q;
  logic              mir_q;
  logic              lock_q;
  logic              in_win;
  logic              wr_ok;
  logic [BANK_W-1:0] bank_d;

  assign in_win = (cpu_addr[ADDR_W-1 -: 3] == 3'b100);
  assign wr_ok  = !rom_sel_n && !cpu_rw && in_win && !lock_q;
  assign bank_d = {cpu_addr[8], cpu_addr[6:2]};

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      bank_q   <= '0;
      size32_q <= 1'b0;
      mir_q    <= 1'b0;
      lock_q   <= 1'b0;
    end else if (wr_ok) begin
      bank_q   <= bank_d;
      size32_q <= cpu_addr[0];
      mir_q    <= cpu_addr[1];
      lock_q   <= cpu_addr[7];
    end
  end

  assign prg_addr_hi = {bank_q[BANK_W-1:1], size32_q ? cpu_addr[14] : bank_q[0]};
  assign mirror_h    = mir_q;

  assert_locked_hold_R9: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> ($stable(bank_q) && $stable(size32_q) && $stable(mir_q) && lock_q));

  assert_outside_window_R1: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr[ADDR_W-1 -: 3] != 3'b100 || rom_sel_n) |=>
      ($stable(bank_q) && $stable(size32_q) && $stable(mir_q) && $stable(lock_q)));

  assert_read_no_effect_R10: assert property (@(posedge clk) disable iff (rst)
    cpu_rw |=> ($stable(bank_q) && $stable(size32_q) && $stable(mir_q) && $stable(lock_q)));

  assert_mirror_load_R4: assert property (@(posedge clk) disable iff (rst)
    wr_ok |=> (mirror_h == $past(cpu_addr[1])));

  assert_bank_upper_R5: assert property (@(posedge clk) disable iff (rst)
    wr_ok |=> (prg_addr_hi[5:1] == {$past(cpu_addr[8]), $past(cpu_addr[6:3])}));

  assert_size_load_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && !cpu_addr[0]) |=> (prg_addr_hi[0] == $past(cpu_addr[2])));

endmodule

// File: tb/prg_latch_mapper_tb_top.sv
`timescale 1ns/1ps
module prg_latch_mapper_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = 16'h0000;
  logic        cpu_rw = 1'b1;
  logic        rom_sel_n = 1'b1;
  logic [5:0]  prg_addr_hi;
  logic        mirror_h;

  int checks = 0;
  int errors = 0;
  int m_bank = 0, m_32 = 0, m_mir = 0, m_lock = 0;

  always #4 clk = ~clk;

  prg_latch_mapper dut_i (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
    .rom_sel_n(rom_sel_n), .prg_addr_hi(prg_addr_hi), .mirror_h(mirror_h)
  );

  function automatic logic [15:0] mk(input int base, input int bank, input int sz,
                                     input int mir, input int lk);
    int a;
    a = base;
    a = a | (((bank >> 0) & 1) << 2) | (((bank >> 1) & 1) << 3)
          | (((bank >> 2) & 1) << 4) | (((bank >> 3) & 1) << 5)
          | (((bank >> 4) & 1) << 6) | (((bank >> 5) & 1) << 8);
    a = a | (sz & 1) | ((mir & 1) << 1) | ((lk & 1) << 7);
    return a[15:0];
  endfunction

  task automatic compare(input string tag);
    int exp_prg;
    exp_prg = (m_32 != 0) ? ((m_bank & 62) | int'(cpu_addr[14])) : m_bank;
    checks++;
    if (prg_addr_hi !== exp_prg[5:0] || mirror_h !== m_mir[0]) begin
      errors++;
      $display("FAIL %s: prg=%0h mir=%0b expected prg=%0h mir=%0b",
               tag, prg_addr_hi, mirror_h, exp_prg[5:0], m_mir[0]);
    end
  endtask

  task automatic step(input logic [15:0] a, input logic rw, input logic sel_n,
                      input string tag);
    int ai;
    @(negedge clk);
    cpu_addr = a; cpu_rw = rw; rom_sel_n = sel_n;
    #1 compare(tag);
    @(posedge clk);
    ai = int'(a);
    if (!sel_n && !rw && a[15:13] == 3'b100 && m_lock == 0) begin
      m_bank = ((ai >> 2) & 31) | (((ai >> 8) & 1) << 5);
      m_32 = ai & 1;
      m_mir = (ai >> 1) & 1;
      m_lock = (ai >> 7) & 1;
    end
    #1;
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    #2 rst = 1'b1;
    #1 m_bank = 0; m_32 = 0; m_mir = 0; m_lock = 0;
    compare(tag);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    #1 compare("R8 reset state");
    repeat (2) @(negedge clk);
    rst = 1'b0;
    step(16'h8000, 1'b1, 1'b0, "R8 after reset");
    step(mk(16'h8000, 6'h2D, 0, 1, 0), 1'b0, 1'b0, "R5 write 16K");
    step(16'h8123, 1'b1, 1'b0, "R6 low half");
    step(16'hC456, 1'b1, 1'b0, "R6 high half");
    step(mk(16'hA000, 6'h12, 1, 0, 0), 1'b0, 1'b0, "R1 write at A000");
    step(mk(16'hC000, 6'h33, 1, 0, 0), 1'b0, 1'b0, "R1 write at C000");
    step(mk(16'hE000, 6'h01, 0, 0, 1), 1'b0, 1'b0, "R1 write at E000");
    step(mk(16'h8000, 6'h07, 1, 0, 0), 1'b0, 1'b1, "R1 strobe inactive");
    step(mk(16'h8000, 6'h07, 1, 0, 0), 1'b1, 1'b0, "R10 read in window");
    step(16'hC000, 1'b1, 1'b0, "R10 no change");
    step(mk(16'h9E00, 6'h13, 1, 0, 0), 1'b0, 1'b0, "R3 write 32K top of window");
    step(16'h8000, 1'b1, 1'b0, "R7 A14 low");
    step(16'hC000, 1'b1, 1'b0, "R7 A14 high");
    step(16'h4000, 1'b1, 1'b1, "R7 A14 high idle");
    step(mk(16'h8000, 6'h3E, 0, 0, 0), 1'b0, 1'b0, "R4 mirror vertical");
    step(16'hFFFF, 1'b1, 1'b0, "R6 even bank high half");
    step(mk(16'h8000, 6'h21, 0, 1, 0), 1'b0, 1'b0, "R2 bank from address");
    step(16'h8000, 1'b1, 1'b0, "R5 A19 bit");
    step(mk(16'h8000, 6'h05, 0, 1, 1), 1'b0, 1'b0, "R9 lock write");
    step(mk(16'h8000, 6'h2A, 1, 0, 0), 1'b0, 1'b0, "R9 attempt after lock");
    step(16'hC000, 1'b1, 1'b0, "R9 still 16K high half");
    step(mk(16'h9000, 6'h3F, 0, 0, 0), 1'b0, 1'b0, "R9 second attempt");
    step(16'h8000, 1'b1, 1'b0, "R9 unchanged");
    do_reset("R8 async reset clears");
    step(16'hC000, 1'b1, 1'b0, "R8 after reset high half");
    step(mk(16'h8000, 6'h1B, 1, 1, 0), 1'b0, 1'b0, "R9 write after reset");
    step(16'hC000, 1'b1, 1'b0, "R9 unlocked 32K");
    step(16'h8000, 1'b1, 1'b0, "R7 32K low half");
    for (int i = 0; i < 8; i++) begin
      step(mk(16'h8000, (i * 23) & 63, i & 1, (i >> 1) & 1, 0), 1'b0, 1'b0, "R5 sweep");
      step({i[0], 15'h0100}, 1'b1, 1'b0, "R6 R7 sweep");
    end
    finish_run();
  end

endmodule